// File: doc/BRIEF.md
# Operating Mode Control Register

This block holds the chip's operating-mode state in one 8-bit register that software can read and, under rules, write. During reset it samples two strap pins and forms one of four modes: single-chip, expanded, bootstrap or test. After reset, software can leave the special modes and adjust the mode variant while a special mode is still in effect. Outside the special modes, the mode can change only through another reset.

The register also drives three controls. The first enables the boot ROM and decodes its address window on the CPU address bus. The second enables internal-read visibility on the external data bus, or, in the single-chip modes, holds the E clock pin low. The third is a 4-bit priority select passed on to the interrupt logic.

Top module: `opmode_ctl`

## Requirements
- R1: Reset is synchronous and active low. At every clock edge while `rst_n` is low, the special bit (bit 6) loads the inverse of `strap_spec_n` and the variant bit (bit 5) loads `strap_ext`. The values from the last edge before release are kept.
- R2: A register write clears the special bit when bit 6 of the write data is 0. A write never sets the special bit.
- R3: The variant bit takes bit 5 of the write data only while the special bit is 1. Otherwise it keeps its value.
- R4: `op_mode` equals {special, variant}, encoded as: 0 = single-chip, 1 = expanded, 2 = bootstrap, 3 = test.
- R5: The boot enable bit (bit 7) resets to 1 in bootstrap mode and to 0 in every other mode. It takes bit 7 of the write data only while the special bit is 1. A write that clears the special bit also forces it to 0. It is never 1 while the special bit is 0.
- R6: `boot_sel` is 1 exactly when boot enable is 1 and `cpu_addr` lies in 16'hBF40..16'hBFFF inclusive.
- R7: `ext_drive` is 1 exactly when the visibility bit (bit 4) is 1, the variant bit is 1 (expanded or test mode), `cpu_rd` is 1 and `cpu_int` is 1.
- R8: `eclk_en` is 0 only when the variant bit is 0 (single-chip or bootstrap) and the visibility bit is 1. In every other case it is 1.
- R9: The priority field (bits 3..0) resets to 4'b0101. It takes bits 3..0 of any register write in any mode, and `pri_sel` shows its value.
- R10: The register answers at `reg_addr` 6'h3C. `reg_rdata` returns all eight bits in the same cycle when `reg_rd` is 1 and the address matches, and returns 0 otherwise. A write to any other address changes nothing.
- R11: The visibility bit resets to 0 and takes bit 4 of any register write in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap pins are sampled while it is low |
| strap_spec_n | input | 1 | Strap pin; low selects a special mode |
| strap_ext | input | 1 | Strap pin; selects the expanded/test variant |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, combinational |
| cpu_addr | input | 16 | CPU address for the boot window decode |
| cpu_rd | input | 1 | CPU read cycle in progress |
| cpu_int | input | 1 | CPU address maps to an internal resource |
| op_mode | output | 2 | Decoded operating mode |
| boot_sel | output | 1 | Boot ROM select |
| ext_drive | output | 1 | Drive internal read data onto the external bus |
| eclk_en | output | 1 | 1 drives the E clock out; 0 holds the pin low |
| pri_sel | output | 4 | Priority select field |

## Verification
Register reads and the three decoded outputs are combinational. The bench therefore samples them a short delay after changing the inputs, within the same cycle. A write takes effect at the clock edge where the strobe is high. The bench drives every write at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. Reset state is checked at the first falling edge after release. That edge is one cycle after the last sampling edge, which lets each strap combination be seen at its own reset.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

    localparam int PRI_W  = 4;
    localparam int DATA_W = PRI_W + 4;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'd0,
        MODE_EXPANDED = 2'd1,
        MODE_BOOT     = 2'd2,
        MODE_TEST     = 2'd3
    } opmode_e;

    // Field order is the register bit layout, MSB first.
    typedef struct packed {
        logic             boot_en;
        logic             special;
        logic             mode_a;
        logic             vis;
        logic [PRI_W-1:0] pri;
    } opmode_reg_t;

    localparam logic [PRI_W-1:0] PRI_RST = 4'b0101;

endpackage

// File: rtl/opmode_state.sv
module opmode_state
    import opmode_pkg::*;
#(
    parameter int                ADDR_W     = 6,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 6'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_spec_n,
    input  logic              strap_ext,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output opmode_reg_t       st_o
);

    opmode_reg_t st_d, st_q, wv;
    logic        wr_hit, rd_hit;

    assign wv     = opmode_reg_t'(reg_wdata);
    assign wr_hit = reg_wr && (reg_addr == REG_OFFSET);
    assign rd_hit = reg_rd && (reg_addr == REG_OFFSET);

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.special = ~strap_spec_n;
            st_d.mode_a  = strap_ext;
            st_d.boot_en = ~strap_spec_n & ~strap_ext;
            st_d.vis     = 1'b0;
            st_d.pri     = PRI_RST;
        end else if (wr_hit) begin
            st_d.special = st_q.special & wv.special;
            if (st_q.special) begin
                st_d.mode_a  = wv.mode_a;
                st_d.boot_en = wv.boot_en & wv.special;
            end
            st_d.vis = wv.vis;
            st_d.pri = wv.pri;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign st_o      = st_q;
    assign reg_rdata = rd_hit ? DATA_W'(st_q) : '0;

    p_spec_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.special |=> !st_q.special);
    p_mode_a_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.special |=> $stable(st_q.mode_a));
    p_boot_implies_spec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.boot_en |-> st_q.special);
    p_pri_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> st_q.pri == $past(reg_wdata[PRI_W-1:0]));
    p_rd_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == '0);

endmodule

// File: rtl/opmode_decode.sv
module opmode_decode
    import opmode_pkg::*;
#(
    parameter int                CPU_AW  = 16,
    parameter logic [CPU_AW-1:0] BOOT_LO = 16'hBF40,
    parameter logic [CPU_AW-1:0] BOOT_HI = 16'hBFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  opmode_reg_t       st_i,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_int,
    output opmode_e           mode_o,
    output logic              boot_sel,
    output logic              ext_drive,
    output logic              eclk_en
);

    logic in_window;

    assign in_window = (cpu_addr >= BOOT_LO) && (cpu_addr <= BOOT_HI);
    assign mode_o    = opmode_e'({st_i.special, st_i.mode_a});
    assign boot_sel  = st_i.boot_en && in_window;
    // Variant bit set means expanded or test: the external bus exists.
    assign ext_drive = st_i.vis && st_i.mode_a && cpu_rd && cpu_int;
    assign eclk_en   = ~(st_i.vis && !st_i.mode_a);

    p_boot_sel_special_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_sel |-> (mode_o == MODE_BOOT || mode_o == MODE_TEST));
    p_ext_drive_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_drive |-> (cpu_rd && cpu_int && eclk_en));
    p_eclk_low_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !eclk_en |-> (mode_o == MODE_SINGLE || mode_o == MODE_BOOT));

endmodule

// File: rtl/opmode_ctl.sv
module opmode_ctl
    import opmode_pkg::*;
#(
    parameter int                ADDR_W     = 6,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 6'h3C,
    parameter int                CPU_AW     = 16,
    parameter logic [CPU_AW-1:0] BOOT_LO    = 16'hBF40,
    parameter logic [CPU_AW-1:0] BOOT_HI    = 16'hBFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_spec_n,
    input  logic              strap_ext,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_int,
    output logic [1:0]        op_mode,
    output logic              boot_sel,
    output logic              ext_drive,
    output logic              eclk_en,
    output logic [3:0]        pri_sel
);

    opmode_reg_t st;
    opmode_e     mode;

    opmode_state #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_spec_n (strap_spec_n),
        .strap_ext    (strap_ext),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_rdata    (reg_rdata),
        .st_o         (st)
    );

    opmode_decode #(.CPU_AW(CPU_AW), .BOOT_LO(BOOT_LO), .BOOT_HI(BOOT_HI)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_i      (st),
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_int   (cpu_int),
        .mode_o    (mode),
        .boot_sel  (boot_sel),
        .ext_drive (ext_drive),
        .eclk_en   (eclk_en)
    );

    assign op_mode = mode;
    assign pri_sel = st.pri;

    p_pri_sel_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pri_sel == 4'b0101);

endmodule

// File: tb/opmode_ctl_bench.sv
module opmode_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_spec_n = 1'b1, strap_ext = 1'b0;
    logic [5:0]  reg_addr = 6'h3C;
    logic [7:0]  reg_wdata = 8'h00;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd = 1'b0, cpu_int = 1'b0;
    logic [1:0]  op_mode;
    logic        boot_sel, ext_drive, eclk_en;
    logic [3:0]  pri_sel;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    opmode_ctl u_opmode_ctl (.*);

    // {strap_spec_n, strap_ext, wdata, read after reset, read after write}
    localparam logic [25:0] VEC [8] = '{
        {1'b1, 1'b0, 8'hFF, 8'h05, 8'h1F},
        {1'b1, 1'b1, 8'h00, 8'h25, 8'h20},
        {1'b0, 1'b0, 8'hE3, 8'hC5, 8'hE3},
        {1'b0, 1'b1, 8'h80, 8'h65, 8'h00},
        {1'b0, 1'b0, 8'h40, 8'hC5, 8'h40},
        {1'b0, 1'b1, 8'h3A, 8'h65, 8'h3A},
        {1'b1, 1'b0, 8'h60, 8'h05, 8'h00},
        {1'b1, 1'b1, 8'hDA, 8'h25, 8'h3A}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic sn, input logic ext);
        @(negedge clk);
        strap_spec_n = sn; strap_ext = ext; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 6'h3C;
    endtask

    task automatic rd(output logic [7:0] d);
        reg_addr = 6'h3C; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
        #1;
    endtask

    task automatic probe(input logic [15:0] a, input logic r, input logic i);
        cpu_addr = a; cpu_rd = r; cpu_int = i;
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        for (int k = 0; k < 8; k++) begin
            do_reset(VEC[k][25], VEC[k][24]);
            rd(r);
            chk("R1 R5 R9 R11 reset readback", 16'(r), 16'(VEC[k][15:8]));
            chk("R4 reset mode", 16'(op_mode), 16'({~VEC[k][25], VEC[k][24]}));
            wr(6'h3C, VEC[k][23:16]);
            rd(r);
            chk("R2 R3 R5 R9 R11 write readback", 16'(r), 16'(VEC[k][7:0]));
            chk("R9 pri_sel", 16'(pri_sel), 16'(VEC[k][3:0]));
        end

        // R6: boot window edges in bootstrap mode
        do_reset(1'b0, 1'b0);
        probe(16'hBF3F, 0, 0); chk("R6 below window", 16'(boot_sel), 16'd0);
        probe(16'hBF40, 0, 0); chk("R6 window low", 16'(boot_sel), 16'd1);
        probe(16'hBFFF, 0, 0); chk("R6 window high", 16'(boot_sel), 16'd1);
        probe(16'hC000, 0, 0); chk("R6 above window", 16'(boot_sel), 16'd0);
        // R5: clearing special forces boot enable off, R4 mode becomes single
        wr(6'h3C, 8'h80);
        probe(16'hBF80, 0, 0); chk("R5 boot_sel after clear", 16'(boot_sel), 16'd0);
        chk("R4 mode after clear", 16'(op_mode), 16'd0);
        do_reset(1'b1, 1'b0);
        probe(16'hBF80, 0, 0); chk("R6 single no boot", 16'(boot_sel), 16'd0);

        // R8: E clock control in single-chip
        chk("R8 eclk reset single", 16'(eclk_en), 16'd1);
        wr(6'h3C, 8'h10);
        chk("R8 eclk held low", 16'(eclk_en), 16'd0);
        probe(16'h0010, 1, 1); chk("R7 no drive in single", 16'(ext_drive), 16'd0);
        wr(6'h3C, 8'h00);
        chk("R8 eclk restored", 16'(eclk_en), 16'd1);

        // R7: visibility in expanded mode
        do_reset(1'b1, 1'b1);
        wr(6'h3C, 8'h15);
        chk("R8 eclk expanded", 16'(eclk_en), 16'd1);
        probe(16'h0010, 1, 1); chk("R7 drive internal read", 16'(ext_drive), 16'd1);
        probe(16'h0010, 1, 0); chk("R7 external addr", 16'(ext_drive), 16'd0);
        probe(16'h0010, 0, 1); chk("R7 no read", 16'(ext_drive), 16'd0);
        wr(6'h3C, 8'h05);
        probe(16'h0010, 1, 1); chk("R7 vis off", 16'(ext_drive), 16'd0);

        // R10: address and strobe gating
        do_reset(1'b0, 1'b1);
        wr(6'h3B, 8'h00);
        rd(r); chk("R10 other offset ignored", 16'(r), 16'h0065);
        reg_addr = 6'h3C; reg_rd = 1'b0; #1;
        chk("R10 no strobe", 16'(reg_rdata), 16'd0);
        reg_addr = 6'h3D; reg_rd = 1'b1; #1;
        chk("R10 wrong address", 16'(reg_rdata), 16'd0);
        reg_rd = 1'b0; reg_addr = 6'h3C;
        // R2 R3: test to expanded by software, then locked
        wr(6'h3C, 8'h25);
        chk("R4 test to expanded", 16'(op_mode), 16'd1);
        wr(6'h3C, 8'h45);
        rd(r); chk("R2 R3 locked after clear", 16'(r), 16'h0025);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule